// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the two-wire serial front end of an audio signal processor. A host addresses it with a 7-bit device address, then sends a subaddress byte and a run of data bytes. The data bytes land in a bank of sixteen 8-bit control registers, whose contents drive the analog sections elsewhere on the chip. The subaddress byte holds the register index and three control flags. One flag steps the index after each byte. One qualifies internal test signals. One suppresses the offset-cancellation cycle that normally follows a write to the source-select register.

On a read addressed to the device, the block returns a live status byte that carries the pilot-detected and soft-mute-active flags. The bus lines are sampled on a system clock at least eight times faster than the serial clock, through two-stage synchronisers. The block only drives SDA, as an open-drain pull-down enable. It never stretches the clock.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: After reset every control register reads 0, and `sda_oe`, `autozero_req` and `test_en` are 0.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged. Any other address is not acknowledged, and all later bytes are then ignored (no acknowledge, no register change) until the next start condition.
- R3: In a write, the byte after the address is the subaddress, and it is acknowledged. Bits [3:0] are the register index, bit 4 enables autoincrement, bit 5 is the test qualifier, bit 6 suppresses autozero, and bit 7 is ignored.
- R4: Each data byte after the subaddress is acknowledged and stored in the register selected by the current index.
- R5: With autoincrement set, the index advances by one after each data byte, and it wraps from 15 to 0.
- R6: With autoincrement clear, every further data byte overwrites the same register.
- R7: Register index 0 is never written. A byte aimed at it is still acknowledged but is discarded.
- R8: A data byte written to index 1 with the suppress flag clear gives exactly one single-cycle `autozero_req` pulse. With the flag set, no pulse appears, but the byte is still stored.
- R9: A read returns status bytes MSB first, for as long as the master acknowledges. Bit 3 is `stereo_det`, bit 2 is `softmute_on`, and all other bits are 0. After a master not-acknowledge, the block releases SDA and goes idle.
- R10: `test_en` is 1 exactly when the test flag of the most recent subaddress byte is 1 and bit 0 of register 15 is 1.
- R11: A repeated start inside a transaction restarts address decoding. A stop returns the block to idle with SDA released, and SDA is only pulled low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the SDA line low |
| stereo_det | input | 1 | Pilot-detected status flag |
| softmute_on | input | 1 | Soft-mute-active status flag |
| regs_flat | output | 128 | Register n on bits [8n+7:8n] |
| autozero_req | output | 1 | One-cycle offset-cancellation request |
| test_en | output | 1 | Qualified enable for internal test signals |

## Verification
The hardest case to reach is one burst in which the autoincrementing index crosses the top of the bank and wraps onto the forbidden index 0. In the same burst it must then carry on into index 1 under the suppress flag. The stimulus sends sixteen data bytes after a single subaddress that starts at index 3. The bench then compares all sixteen registers with an arithmetic model and counts autozero pulses. A second hard case is the end of a read: the block must let go of SDA after the master's not-acknowledge, otherwise the stop condition cannot be formed. Every read therefore ends with a not-acknowledge and a stop, and the bench checks that SDA is released afterwards.

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h46,
  parameter int IDX_W    = 4,
  parameter int AZ_IDX   = 1,
  parameter int TEST_IDX = 15,
  parameter int ST_POS   = 3,
  parameter int SM_POS   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_in,
  input  logic                        sda_in,
  output logic                        sda_oe,
  input  logic                        stereo_det,
  input  logic                        softmute_on,
  output logic [8*(1<<IDX_W)-1:0]     regs_flat,
  output logic                        autozero_req,
  output logic                        test_en
);
  localparam int NREG   = 1 << IDX_W;
  localparam int INC_B  = IDX_W;
  localparam int TST_B  = IDX_W + 1;
  localparam int KEEP_B = IDX_W + 2;
  localparam logic [IDX_W-1:0] ONE  = 1;
  localparam logic [IDX_W-1:0] AZ_I = AZ_IDX[IDX_W-1:0];

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_WR, S_RD} st_t;
  st_t st;

  logic [2:0] scl_r, sda_r;
  logic [3:0] bitc;
  logic [7:0] sh, stat;
  logic [IDX_W-1:0] idx;
  logic f_inc, f_test, f_keep, mnack;
  logic [7:0] regs [NREG];

  wire scl_rise = scl_r[1] & ~scl_r[2];
  wire scl_fall = ~scl_r[1] & scl_r[2];
  wire start_c  = scl_r[1] & scl_r[2] & sda_r[2] & ~sda_r[1];
  wire stop_c   = scl_r[1] & scl_r[2] & ~sda_r[2] & sda_r[1];
  wire wr_fire  = (st == S_WR) && scl_fall && (bitc == 4'd8) && !start_c && !stop_c;

  always_comb begin
    stat = 8'h00;
    stat[ST_POS] = stereo_det;
    stat[SM_POS] = softmute_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_in};
      sda_r <= {sda_r[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitc <= '0;
      sh <= '0;
      idx <= '0;
      f_inc <= 1'b0;
      f_test <= 1'b0;
      f_keep <= 1'b0;
      mnack <= 1'b0;
      sda_oe <= 1'b0;
      autozero_req <= 1'b0;
    end else begin
      autozero_req <= 1'b0;
      if (start_c) begin
        st <= S_ADDR;
        bitc <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitc != 4'd9) bitc <= bitc + 4'd1;
          sh <= {sh[6:0], sda_r[1]};
          if (bitc == 4'd8) mnack <= sda_r[1];
        end else if (scl_fall) begin
          if (bitc == 4'd8) begin
            case (st)
              S_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st <= sh[0] ? S_RD : S_SUB;
                end else begin
                  st <= S_IDLE;
                end
              end
              S_SUB: begin
                sda_oe <= 1'b1;
                idx <= sh[IDX_W-1:0];
                f_inc <= sh[INC_B];
                f_test <= sh[TST_B];
                f_keep <= sh[KEEP_B];
                st <= S_WR;
              end
              S_WR: begin
                sda_oe <= 1'b1;
                if (f_inc) idx <= idx + ONE;
                if (idx == AZ_I && !f_keep) autozero_req <= 1'b1;
              end
              S_RD: sda_oe <= 1'b0;
              default: ;
            endcase
          end else if (bitc == 4'd9) begin
            bitc <= '0;
            if (st == S_RD) begin
              if (mnack) begin
                st <= S_IDLE;
                sda_oe <= 1'b0;
              end else begin
                sh <= stat;
                sda_oe <= ~stat[7];
              end
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (st == S_RD) begin
            sda_oe <= ~sh[7];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_fire && idx != '0) begin
      regs[idx] <= sh;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[8*g +: 8] = regs[g];
  end

  assign test_en = f_test & regs[TEST_IDX][0];
endmodule

module i2c_ctrl_slave_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_q,
  input logic         idle,
  input logic         sda_oe,
  input logic         autozero_req,
  input logic         test_en,
  input logic [W-1:0] regs_flat
);
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    autozero_req |=> !autozero_req);
  a_r2_idle_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(regs_flat));
  a_r10_idle_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(test_en));
  a_r8_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !autozero_req);
endmodule

bind i2c_ctrl_slave i2c_ctrl_slave_chk #(.W(8*NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_r[1]), .idle(st == S_IDLE),
  .sda_oe(sda_oe), .autozero_req(autozero_req), .test_en(test_en),
  .regs_flat(regs_flat)
);

// File: tb/i2c_ctrl_slave_bench.sv
module i2c_ctrl_slave_bench;
  localparam int CLK_P = 10;
  localparam logic [6:0] DEV = 7'h46;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic st_in = 1'b0, sm_in = 1'b0;
  logic sda_oe, az, ten;
  logic [127:0] regs_flat;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, az_cnt = 0, az_exp = 0;
  logic [7:0] exp_r [16];
  logic [3:0] m_idx;
  logic m_inc, m_keep;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_ctrl_slave #(.DEV_ADDR(DEV)) u_i2c_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .stereo_det(st_in), .softmute_on(sm_in),
    .regs_flat(regs_flat), .autozero_req(az), .test_en(ten)
  );

  always @(posedge clk) if (az) az_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      q(); sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
    end
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
    end
    q(); sda_m = ~mack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
  endtask

  task automatic open_wr();
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    check("R2 address ack", a, 1);
  endtask

  task automatic wr_sub(input logic [7:0] s);
    logic a;
    send_byte(s, a);
    check("R3 subaddress ack", a, 1);
    m_idx = s[3:0]; m_inc = s[4]; m_keep = s[6];
  endtask

  task automatic wr_data(input logic [7:0] b);
    logic a;
    send_byte(b, a);
    check("R4 data ack", a, 1);
    if (m_idx != 4'd0) exp_r[m_idx] = b;
    if (m_idx == 4'd1 && !m_keep) az_exp++;
    if (m_inc) m_idx = m_idx + 4'd1;
  endtask

  task automatic cmp_regs(input string tag);
    for (int i = 0; i < 16; i++) check(tag, regs_flat[8*i +: 8], exp_r[i]);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < 16; i++) exp_r[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_regs("R1 reset registers");
    check("R1 reset sda_oe", sda_oe, 0);
    check("R1 reset autozero", az, 0);
    check("R1 reset test_en", ten, 0);

    // R4 single write to every index, R8 pulse on index 1
    for (int k = 1; k < 16; k++) begin
      open_wr();
      wr_sub({4'b0000, k[3:0]});
      wr_data(k[7:0] * 8'd29 + 8'd7);
      bus_stop();
    end
    cmp_regs("R4 single writes");
    check("R8 autozero count", az_cnt, az_exp);

    // R5 burst wrapping 15 -> 0 -> 1 with suppress set, R7 index 0 skipped
    open_wr();
    wr_sub({1'b0, 1'b1, 1'b0, 1'b1, 4'd3});
    for (int k = 0; k < 16; k++) wr_data(8'hA0 + k[7:0]);
    bus_stop();
    cmp_regs("R5 R7 wrap burst");
    check("R8 suppressed burst", az_cnt, az_exp);

    // R6 overwrite without autoincrement
    open_wr();
    wr_sub({4'b0000, 4'd5});
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h33); wr_data(8'h44);
    bus_stop();
    cmp_regs("R6 overwrite");

    // R7 direct write to index 0
    open_wr();
    wr_sub({4'b0000, 4'd0});
    wr_data(8'hFF);
    bus_stop();
    check("R7 index 0 untouched", regs_flat[7:0], 8'h00);

    // R8 autozero with and without suppress
    open_wr(); wr_sub({4'b0000, 4'd1}); wr_data(8'h3C); bus_stop();
    check("R8 pulse when not suppressed", az_cnt, az_exp);
    open_wr(); wr_sub({4'b0100, 4'd1}); wr_data(8'hC3); bus_stop();
    check("R8 no pulse when suppressed", az_cnt, az_exp);
    check("R8 byte still stored", regs_flat[15:8], 8'hC3);

    // R2 foreign address ignored
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    check("R2 foreign address nack", a, 0);
    send_byte({4'b0000, 4'd2}, a);
    check("R2 ignored sub nack", a, 0);
    send_byte(8'h99, a);
    check("R2 ignored data nack", a, 0);
    bus_stop();
    cmp_regs("R2 no change after foreign address");

    // R9 status read for all flag combinations
    for (int c = 0; c < 4; c++) begin
      st_in = c[1]; sm_in = c[0];
      bus_start();
      send_byte({DEV, 1'b1}, a);
      check("R9 read address ack", a, 1);
      recv_byte(1'b1, b);
      check("R9 status byte 1", b, {4'b0000, c[1], c[0], 2'b00});
      recv_byte(1'b0, b);
      check("R9 status byte 2", b, {4'b0000, c[1], c[0], 2'b00});
      bus_stop();
      check("R9 released after nack", sda_oe, 0);
    end

    // R10 test qualifier combinations
    for (int t = 0; t < 2; t++) begin
      for (int d = 0; d < 2; d++) begin
        open_wr();
        wr_sub({2'b00, t[0], 1'b0, 4'd15});
        wr_data({7'b1010101, d[0]});
        bus_stop();
        check("R10 test_en", ten, t & d);
      end
    end
    open_wr(); wr_sub({4'b0000, 4'd2}); bus_stop();
    check("R10 test flag cleared by new subaddress", ten, 0);

    // R11 repeated start
    open_wr();
    wr_sub({4'b0000, 4'd4});
    wr_data(8'h5A);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    check("R11 address after repeated start", a, 1);
    wr_sub({4'b0000, 4'd6});
    wr_data(8'hA5);
    bus_stop();
    cmp_regs("R11 repeated start writes");
    check("R11 idle released", sda_oe, 0);
    check("R8 final autozero count", az_cnt, az_exp);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog R11 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule